// File: doc/BRIEF.md
# Multi-Requester Watchdog Timer

This block is a watchdog counter run by a slow tick. Software programs a timeout limit and picks which of up to eight reload slots take part. It also chooses whether counting goes on or stops while the CPU sleeps and while a debugger holds it halted. Software then starts the counter. Once started, the watchdog cannot be stopped by anything but a reset. Its settings are frozen from that point.

The count restarts only when every participating slot has been written with a fixed 32-bit key since the last restart. This lets several independent software agents each prove that they are alive. When the count runs out, the block sets a timeout flag and can raise an interrupt. A short number of ticks later it pulses a system reset request, which leaves a handler time to react. Registers sit on a simple word-addressed bus with a single-cycle write strobe and a combinational read path.

Top module: `wdog_multi_slot`

## Requirements
- R1: After reset the block is stopped and has no flags set. The reset outputs and the interrupt are low. The limit register reads 0xFFFFFFFF, the slot mask reads 0x01, and the mode register reads 0x1.
- R2: Writing a word with bit 0 set to the start register (byte offset 0x000) starts the watchdog. Bit 0 of the run register (0x400) then reads 1 and stays 1 until reset, whatever is written afterwards.
- R3: With no restart, the timeout flag rises after exactly LIMIT+1 counted ticks from start, where LIMIT is the register at 0x504. The count then reloads LIMIT and continues.
- R4: The mode register (0x50C) controls counting while the CPU is stopped. When bit 0 is 1, ticks count while the sleep input is high; when it is 0 they do not. Bit 3 does the same for the debug-halt input. A tick that is not counted leaves the count unchanged.
- R5: Slot n sits at byte offset 0x600+4n. A slot's request is recorded only when three conditions hold: the watchdog runs, bit n of the slot mask (0x508) is set, and the written word equals 0x6E524635. Any other value, a masked slot, or a stopped watchdog leaves the request state unchanged.
- R6: When the last enabled slot records its request, the count reloads LIMIT in that same clock cycle and every request is cleared.
- R7: Bit n of the pending register (0x404) reads 1 exactly when slot n is enabled and has not yet requested since the last restart.
- R8: Writing bit 0 = 1 at 0x304 enables the interrupt, and writing bit 0 = 1 at 0x308 disables it. Both addresses read back the enable in bit 0. The interrupt output equals the timeout flag ANDed with the enable.
- R9: The timeout flag (0x100, bit 0) stays set until software writes a word with bit 0 = 0 there.
- R10: The reset request output is a one-cycle pulse. It appears in the cycle after the second raw tick that follows the expiring tick.
- R11: While the watchdog runs, writes to the limit, slot mask and mode registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per slow-clock tick |
| cpu_sleep | input | 1 | High while the CPU sleeps |
| cpu_halt | input | 1 | High while a debugger halts the CPU |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address (byte offset divided by four) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Timeout interrupt, level |
| reset_req | output | 1 | System reset request pulse |

## Verification
The embedded properties assume three things. tick_en is a strobe, sleep and halt are plain levels, and a key write never lands in the same cycle as the tick that expires the count. They also assume the limit is large enough that one expiry's reset delay ends before the next expiry. The stimulus drives ticks and bus writes as separate operations, so no cycle carries both. It picks limits of at least three, so two reset delays never overlap. It changes sleep and halt only between ticks, which lets the bench model treat each tick as counted or not.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   // word addresses (byte offset / 4); software decodes these
   localparam int unsigned WA_START  = 32'h000;
   localparam int unsigned WA_EVENT  = 32'h040;
   localparam int unsigned WA_INTSET = 32'h0C1;
   localparam int unsigned WA_INTCLR = 32'h0C2;
   localparam int unsigned WA_RUN    = 32'h100;
   localparam int unsigned WA_PEND   = 32'h101;
   localparam int unsigned WA_LIMIT  = 32'h141;
   localparam int unsigned WA_MASK   = 32'h142;
   localparam int unsigned WA_MODE   = 32'h143;
   localparam int unsigned WA_SLOT0  = 32'h180;

   localparam logic [31:0] RELOAD_KEY = 32'h6E52_4635;

   // mode register bit positions
   localparam int unsigned MODE_SLEEP_BIT = 0;
   localparam int unsigned MODE_HALT_BIT  = 3;

   typedef struct packed {
      logic halt_run;
      logic sleep_run;
   } wd_mode_t;
endpackage

// File: rtl/wdog_slot_tracker.sv
`timescale 1ns/1ps
module wdog_slot_tracker #(
   parameter int unsigned       NUM_SLOTS = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] KEY       = DATA_W'(32'h6E52_4635)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [NUM_SLOTS-1:0] slot_wr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_SLOTS-1:0] enable_mask,
   output logic                 reload_o,
   output logic [NUM_SLOTS-1:0] pending_o
);
   logic [NUM_SLOTS-1:0] flags_q;
   logic [NUM_SLOTS-1:0] hit;
   logic [NUM_SLOTS-1:0] req_next;
   logic                 key_ok;

   assign key_ok = (wdata == KEY);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign hit[i] = active && slot_wr[i] && enable_mask[i] && key_ok;
   end

   assign req_next  = flags_q | hit;
   assign reload_o  = (|hit) && ((req_next & enable_mask) == enable_mask);
   assign pending_o = enable_mask & ~flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_q <= '0;
      else if (reload_o) flags_q <= '0;
      else               flags_q <= req_next;
   end

   // R7: no request is ever held for a masked slot
   p_flags_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~enable_mask) == '0));
   // R6: a restart leaves every slot asking again
   p_reload_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reload_o |=> (flags_q == '0));
endmodule

// File: rtl/wdog_countdown.sv
`timescale 1ns/1ps
module wdog_countdown #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned RST_DELAY = 2,
   localparam int unsigned DLY_W    = $clog2(RST_DELAY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             reload_i,
   input  logic             step_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o,
   output logic             reset_req_o
);
   if (RST_DELAY < 1) begin : g_bad_delay
      $error("RST_DELAY must be at least one tick");
   end

   logic [CNT_W-1:0] count_q;
   logic [DLY_W-1:0] dly_q;

   assign expire_o = step_i && !start_i && !reload_i && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count_q <= '0;
      else if (start_i || reload_i)    count_q <= limit_i;
      else if (expire_o)               count_q <= limit_i;
      else if (step_i)                 count_q <= count_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q       <= '0;
         reset_req_o <= 1'b0;
      end else begin
         reset_req_o <= tick_i && (dly_q == DLY_W'(1));
         if (expire_o)                      dly_q <= DLY_W'(RST_DELAY);
         else if (tick_i && dly_q != '0)    dly_q <= dly_q - 1'b1;
      end
   end

   // R3: the count never exceeds the programmed limit
   p_count_le_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q <= limit_i));
   // R10: the reset request lasts one cycle
   p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req_o |=> !reset_req_o);
endmodule

// File: rtl/wdog_multi_slot.sv
`timescale 1ns/1ps
module wdog_multi_slot
   import wdog_pkg::*;
#(
   parameter int unsigned NUM_SLOTS  = 8,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned RST_DELAY  = 2,
   parameter logic [31:0] LIMIT_RST  = 32'hFFFF_FFFF,
   parameter logic [15:0] MASK_RST   = 16'h0001,
   parameter logic        SLEEP_RUN_RST = 1'b1,
   parameter logic        HALT_RUN_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cpu_sleep,
   input  logic              cpu_halt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              reset_req
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > 16) begin : g_bad_slots
      $error("NUM_SLOTS must be 1..16");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (DATA_W < 32 || CNT_W > DATA_W || CNT_W > 32) begin : g_bad_width
      $error("DATA_W must hold the key and the count");
   end

   localparam logic [ADDR_W-1:0] AW_START  = ADDR_W'(WA_START);
   localparam logic [ADDR_W-1:0] AW_EVENT  = ADDR_W'(WA_EVENT);
   localparam logic [ADDR_W-1:0] AW_INTSET = ADDR_W'(WA_INTSET);
   localparam logic [ADDR_W-1:0] AW_INTCLR = ADDR_W'(WA_INTCLR);
   localparam logic [ADDR_W-1:0] AW_RUN    = ADDR_W'(WA_RUN);
   localparam logic [ADDR_W-1:0] AW_PEND   = ADDR_W'(WA_PEND);
   localparam logic [ADDR_W-1:0] AW_LIMIT  = ADDR_W'(WA_LIMIT);
   localparam logic [ADDR_W-1:0] AW_MASK   = ADDR_W'(WA_MASK);
   localparam logic [ADDR_W-1:0] AW_MODE   = ADDR_W'(WA_MODE);
   localparam logic [ADDR_W-1:0] AW_SLOT0  = ADDR_W'(WA_SLOT0);

   logic                 running_q;
   logic [CNT_W-1:0]     limit_q;
   logic [NUM_SLOTS-1:0] mask_q;
   wd_mode_t             mode_q;
   logic                 inten_q;
   logic                 event_q;
   logic [NUM_SLOTS-1:0] slot_wr;
   logic [NUM_SLOTS-1:0] pending;
   logic                 reload;
   logic                 expire;
   logic                 start_pulse;
   logic                 step;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_dec
      assign slot_wr[i] = bus_wr && (bus_addr == AW_SLOT0 + ADDR_W'(i));
   end

   assign start_pulse = bus_wr && (bus_addr == AW_START) && bus_wdata[0] && !running_q;
   assign step = tick_en && running_q
               && (mode_q.sleep_run || !cpu_sleep)
               && (mode_q.halt_run  || !cpu_halt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         limit_q   <= CNT_W'(LIMIT_RST);
         mask_q    <= NUM_SLOTS'(MASK_RST);
         mode_q    <= '{halt_run: HALT_RUN_RST, sleep_run: SLEEP_RUN_RST};
         inten_q   <= 1'b0;
         event_q   <= 1'b0;
      end else begin
         if (start_pulse) running_q <= 1'b1;
         if (bus_wr && !running_q) begin
            if (bus_addr == AW_LIMIT) limit_q <= bus_wdata[CNT_W-1:0];
            if (bus_addr == AW_MASK)  mask_q  <= bus_wdata[NUM_SLOTS-1:0];
            if (bus_addr == AW_MODE)
               mode_q <= '{halt_run:  bus_wdata[MODE_HALT_BIT],
                           sleep_run: bus_wdata[MODE_SLEEP_BIT]};
         end
         if (bus_wr && bus_addr == AW_INTSET && bus_wdata[0])      inten_q <= 1'b1;
         else if (bus_wr && bus_addr == AW_INTCLR && bus_wdata[0]) inten_q <= 1'b0;
         if (expire)                                              event_q <= 1'b1;
         else if (bus_wr && bus_addr == AW_EVENT && !bus_wdata[0]) event_q <= 1'b0;
      end
   end

   wdog_slot_tracker #(
      .NUM_SLOTS (NUM_SLOTS),
      .DATA_W    (DATA_W),
      .KEY       (DATA_W'(RELOAD_KEY))
   ) i_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (running_q),
      .slot_wr     (slot_wr),
      .wdata       (bus_wdata),
      .enable_mask (mask_q),
      .reload_o    (reload),
      .pending_o   (pending)
   );

   wdog_countdown #(
      .CNT_W     (CNT_W),
      .RST_DELAY (RST_DELAY)
   ) i_countdown (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_pulse),
      .reload_i    (reload),
      .step_i      (step),
      .tick_i      (tick_en),
      .limit_i     (limit_q),
      .expire_o    (expire),
      .reset_req_o (reset_req)
   );

   assign irq = event_q && inten_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW_EVENT:  bus_rdata[0] = event_q;
         AW_INTSET: bus_rdata[0] = inten_q;
         AW_INTCLR: bus_rdata[0] = inten_q;
         AW_RUN:    bus_rdata[0] = running_q;
         AW_PEND:   bus_rdata[NUM_SLOTS-1:0] = pending;
         AW_LIMIT:  bus_rdata[CNT_W-1:0] = limit_q;
         AW_MASK:   bus_rdata[NUM_SLOTS-1:0] = mask_q;
         AW_MODE: begin
            bus_rdata[MODE_SLEEP_BIT] = mode_q.sleep_run;
            bus_rdata[MODE_HALT_BIT]  = mode_q.halt_run;
         end
         default:   bus_rdata = '0;
      endcase
   end

   // R2: once started the watchdog keeps running
   p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |=> running_q);
   // R11: configuration is frozen while running
   p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      running_q |=> ($stable(limit_q) && $stable(mask_q) && $stable(mode_q)));
endmodule

// File: tb/test_wdog_multi_slot.sv
`timescale 1ns/1ps
module test_wdog_multi_slot;
   localparam logic [31:0] KEY = 32'h6E52_4635;
   localparam int B_START = 'h000, B_EVENT = 'h100, B_INTSET = 'h304, B_INTCLR = 'h308;
   localparam int B_RUN = 'h400, B_PEND = 'h404, B_LIMIT = 'h504, B_MASK = 'h508;
   localparam int B_MODE = 'h50C, B_SLOT0 = 'h600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, cpu_sleep = 1'b0, cpu_halt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, reset_req;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   // bench model state
   bit          m_run, m_sleep_run, m_halt_run, m_inten, m_event, m_rr;
   logic [31:0] m_limit, m_cnt;
   logic [7:0]  m_mask, m_flags;
   int          m_dly;

   always #10 clk = ~clk;

   wdog_multi_slot i_wdog_multi_slot (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_sleep(cpu_sleep),
      .cpu_halt(cpu_halt), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .reset_req(reset_req));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int boff, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'(boff >> 2); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int boff, output logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 10'(boff >> 2);
      #1 d = bus_rdata;
   endtask

   task automatic read_chk(input string req, input int boff, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(boff, v);
      chk(req, v, exp);
   endtask

   function automatic bit counted(input bit s, input bit h);
      return m_run && (m_sleep_run || !s) && (m_halt_run || !h);
   endfunction

   task automatic model_reset();
      m_run = 0; m_sleep_run = 1; m_halt_run = 0; m_inten = 0; m_event = 0;
      m_rr = 0; m_limit = 32'hFFFF_FFFF; m_cnt = 0; m_mask = 8'h01; m_flags = 0; m_dly = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic do_tick(input bit s, input bit h);
      m_rr = (m_dly == 1);
      if (m_dly != 0) m_dly--;
      if (counted(s, h)) begin
         if (m_cnt == 0) begin m_event = 1; m_cnt = m_limit; m_dly = 2; end
         else m_cnt = m_cnt - 1;
      end
      @(negedge clk);
      tick_en = 1'b1; cpu_sleep = s; cpu_halt = h;
      @(negedge clk);
      tick_en = 1'b0; cpu_sleep = 1'b0; cpu_halt = 1'b0;
      chk("R10 reset request timing", {31'b0, reset_req}, {31'b0, m_rr});
   endtask

   task automatic do_key(input int slot, input logic [31:0] d);
      if (m_run && m_mask[slot] && d == KEY) begin
         m_flags[slot] = 1'b1;
         if ((m_flags & m_mask) == m_mask) begin m_flags = 0; m_cnt = m_limit; end
      end
      bus_write(B_SLOT0 + 4 * slot, d);
   endtask

   task automatic check_state(input string req);
      read_chk({req, " timeout flag"}, B_EVENT, {31'b0, m_event});
      read_chk({req, " pending"}, B_PEND, {24'b0, m_mask & ~m_flags});
      chk({req, " irq"}, {31'b0, irq}, {31'b0, m_event & m_inten});
   endtask

   task automatic program_and_start(input logic [31:0] lim, input logic [7:0] msk,
                                    input bit sr, input bit hr, input bit ie);
      bus_write(B_LIMIT, lim);  m_limit = lim;
      bus_write(B_MASK, {24'b0, msk}); m_mask = msk;
      bus_write(B_MODE, {28'b0, hr, 2'b0, sr}); m_sleep_run = sr; m_halt_run = hr;
      if (ie) bus_write(B_INTSET, 32'h1); else bus_write(B_INTCLR, 32'h1);
      m_inten = ie;
      bus_write(B_START, 32'h1); m_run = 1; m_cnt = m_limit;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog: actual=hung expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();

      // R1: reset state
      read_chk("R1 run", B_RUN, 32'h0);
      read_chk("R1 flag", B_EVENT, 32'h0);
      read_chk("R1 limit", B_LIMIT, 32'hFFFF_FFFF);
      read_chk("R1 mask", B_MASK, 32'h1);
      read_chk("R1 mode", B_MODE, 32'h1);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 reset_req", {31'b0, reset_req}, 32'h0);

      // R5: key write while stopped is ignored
      do_key(0, KEY);
      read_chk("R5 stopped slot write", B_PEND, 32'h1);

      // R8: interrupt enable set/clear
      bus_write(B_INTSET, 32'h1);
      read_chk("R8 enable via set reg", B_INTSET, 32'h1);
      bus_write(B_INTCLR, 32'h1);
      read_chk("R8 enable via clear reg", B_INTCLR, 32'h0);

      program_and_start(32'd4, 8'h05, 1'b1, 1'b1, 1'b1);
      read_chk("R2 running", B_RUN, 32'h1);
      read_chk("R8 enable readback", B_INTSET, 32'h1);

      // R11: configuration frozen
      bus_write(B_LIMIT, 32'd100);
      bus_write(B_MASK, 32'hFF);
      bus_write(B_MODE, 32'h0);
      read_chk("R11 limit locked", B_LIMIT, 32'd4);
      read_chk("R11 mask locked", B_MASK, 32'h5);
      read_chk("R11 mode locked", B_MODE, 32'h9);
      read_chk("R7 pending after start", B_PEND, 32'h5);

      // R5: wrong value, masked slot
      do_key(0, 32'h1234_5678);
      read_chk("R5 wrong key ignored", B_PEND, 32'h5);
      do_key(1, KEY);
      read_chk("R5 masked slot ignored", B_PEND, 32'h5);
      do_key(0, KEY);
      read_chk("R7 slot0 requested", B_PEND, 32'h4);
      do_key(2, KEY);
      read_chk("R6 all requested, flags cleared", B_PEND, 32'h5);

      // R3: expiry after LIMIT+1 ticks
      for (int i = 0; i < 4; i++) begin
         do_tick(1'b0, 1'b0);
         read_chk("R3 no early timeout", B_EVENT, 32'h0);
      end
      do_tick(1'b1, 1'b0);
      read_chk("R3 timeout after LIMIT+1 ticks", B_EVENT, 32'h1);
      chk("R8 irq on timeout", {31'b0, irq}, 32'h1);

      // R10: reset request pulse two ticks later
      do_tick(1'b0, 1'b0);
      chk("R10 no request after first tick", {31'b0, reset_req}, 32'h0);
      do_tick(1'b0, 1'b0);
      chk("R10 request after second tick", {31'b0, reset_req}, 32'h1);
      @(negedge clk);
      chk("R10 single-cycle pulse", {31'b0, reset_req}, 32'h0);

      // R9: sticky flag, cleared by writing 0
      bus_write(B_EVENT, 32'h1);
      read_chk("R9 flag stays", B_EVENT, 32'h1);
      bus_write(B_EVENT, 32'h0); m_event = 0;
      read_chk("R9 flag cleared", B_EVENT, 32'h0);
      chk("R9 irq dropped", {31'b0, irq}, 32'h0);

      // R2: cannot stop
      bus_write(B_START, 32'h0);
      read_chk("R2 still running", B_RUN, 32'h1);

      // R3 R4 R5 R6 R7: random rounds, one per pause mode
      for (int round = 0; round < 4; round++) begin
         do_reset();
         read_chk("R1 run after reset", B_RUN, 32'h0);
         program_and_start(32'd3 + ($urandom % 6), 8'($urandom), round[0], round[1],
                           1'($urandom));
         for (int op = 0; op < 250; op++) begin
            int r;
            r = $urandom % 8;
            if (r < 4) do_tick(($urandom % 4) == 0, ($urandom % 4) == 0);
            else if (r < 7) do_key($urandom % 8, (($urandom % 3) != 0) ? KEY : $urandom);
            else begin bus_write(B_EVENT, 32'h0); m_event = 0; end
            check_state("R3 R4 R5 R6 R7 R8");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule